// File: doc/BRIEF.md
# Configuration Command Controller

This block runs board configuration transactions issued by software through three 32-bit registers: a data register, a control register and a status register. Software first writes the control register with a set of command fields. If that write also carries the launch bit, the controller checks the addressed target and carries out the command against an on-chip target model. The model holds a parameterised table of daughterboard voltage sensors (in microvolts), a fixed motherboard bus voltage, two no-effect configuration functions, and the shutdown and reboot request lines.

A transaction always takes one cycle. When it ends, the status register shows a done flag and, if the command was refused, a fault flag. A successful read leaves its result in the data register. A write command sends the value currently held in the data register. Shutdown and reboot are each issued as a one-cycle pulse.

The sequencing is a two-state machine. IDLE is the reset state, and bus writes are accepted in it. The transition IDLE to EXEC is taken on a control write whose launch bit is set. In EXEC the target model is evaluated and the result is committed. The transition EXEC to IDLE is always taken on the following edge.

Top module: `cfg_cmd_ctrl`

## Requirements
- R1: After reset, the data (offset 0xA0), control (0xA4) and status (0xA8) registers read 0, and both request outputs are low.
- R2: A control write stores every bit except bit 31 (launch) and bits 19:18, which always read 0. A control write with bit 31 clear starts no transaction, and the status register is left unchanged.
- R3: A control write with bit 31 set starts a transaction. The status register still reads its old value in the cycle after that write edge. After the next edge it reads 1 (done) on success or 3 (done and fault) on failure.
- R4: Control fields: bit 30 selects write (1) or read (0), 29:26 select the controller, 25:20 the function, 17:16 the site, 15:12 the stack position and 11:0 the device. A command faults unless the controller is 0, the position is 0 and the site is 0 (motherboard) or 1 (daughterboard).
- R5: A read with function 2 at site 1 and a device below NUM_SENSORS loads entry [device] of the sensor table into the data register. The default table is 900000, 1000000, 1200000, 1800000 for devices 0 to 3.
- R6: A read with function 2 at site 0, device 0 loads 3300000 into the data register. Every other read faults and leaves the data register unchanged.
- R7: A write with function 8 to site 0, device 0 pulses shutdown_req for exactly one cycle. Function 9 to the same target pulses reboot_req. Either pulse is high in the same cycle that the status reads done. The same functions sent to any other target fault and produce no pulse.
- R8: Writes with function 7 or 11 to site 0, device 0 succeed with no side effect. Every other write combination faults. A write command never changes the data register.
- R9: A bus write to the status register stores only bits 1:0. All other bits read 0.
- R10: Bus writes that arrive during the EXEC cycle are dropped.
- R11: Reads of any offset other than 0xA0, 0xA4 or 0xA8 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from bus_addr without a register stage |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The hardest case to reach is a bus write that falls inside the single EXEC cycle, because EXEC lasts only one edge. The bench reaches it by issuing a data write on the edge directly after a launching control write. The launched command is chosen to fault, so the data register must keep its earlier value, and the dropped write becomes visible at the ports. The same back-to-back timing is used to sample the status register before and after the commit edge.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;
    localparam int unsigned DW = 32;

    localparam logic [7:0] OFF_DATA = 8'hA0;
    localparam logic [7:0] OFF_CTRL = 8'hA4;
    localparam logic [7:0] OFF_STAT = 8'hA8;

    localparam logic [DW-1:0] CTRL_KEEP_MASK = 32'h7FF3_FFFF;

    localparam logic [5:0] FN_VOLT     = 6'd2;
    localparam logic [5:0] FN_VIDSEL   = 6'd7;
    localparam logic [5:0] FN_SHUTDOWN = 6'd8;
    localparam logic [5:0] FN_REBOOT   = 6'd9;
    localparam logic [5:0] FN_DVI      = 6'd11;

    localparam logic [DW-1:0] MB_BUS_UV = 32'd3_300_000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } cmd_state_e;

    typedef struct packed {
        logic       launch;
        logic       is_write;
        logic [3:0] ctl_sel;
        logic [5:0] func;
        logic [1:0] spare;
        logic [1:0] site;
        logic [3:0] pos;
        logic [11:0] dev;
    } cmd_word_t;
endpackage

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
    import cfg_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic exec
);
    cmd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        exec = 1'b0;
        unique case (state_q)
            ST_IDLE: exec = 1'b0;
            ST_EXEC: exec = 1'b1;
        endcase
    end

    // R10: the execution window lasts one cycle only
    a_r10_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);
    // R3: a launch leads into execution on the next edge
    a_r3_launch_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !exec) |=> exec);
endmodule

// File: rtl/cfg_cmd_target.sv
module cfg_cmd_target
    import cfg_cmd_pkg::*;
#(
    parameter int unsigned NUM_SENSORS = 4,
    parameter logic [NUM_SENSORS*32-1:0] SENSOR_UV =
        {32'd1_800_000, 32'd1_200_000, 32'd1_000_000, 32'd900_000}
) (
    input  cmd_word_t        cmd,
    output logic             ok,
    output logic [DW-1:0]    rd_val,
    output logic             want_shutdown,
    output logic             want_reboot
);
    localparam int unsigned IDXW = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1;

    logic [DW-1:0] sens [NUM_SENSORS];
    for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sens
        assign sens[g] = SENSOR_UV[g*32 +: 32];
    end

    logic valid_tgt, mb_dev0, db_hit;
    assign valid_tgt = (cmd.ctl_sel == 4'd0) && (cmd.pos == 4'd0) && (cmd.site <= 2'd1);
    assign mb_dev0   = (cmd.site == 2'd0) && (cmd.dev == 12'd0);
    assign db_hit    = (cmd.site == 2'd1) && (32'(cmd.dev) < NUM_SENSORS);

    always_comb begin
        ok            = 1'b0;
        rd_val        = '0;
        want_shutdown = 1'b0;
        want_reboot   = 1'b0;
        if (valid_tgt) begin
            if (!cmd.is_write) begin
                if (cmd.func == FN_VOLT) begin
                    if (db_hit) begin
                        ok     = 1'b1;
                        rd_val = sens[cmd.dev[IDXW-1:0]];
                    end else if (mb_dev0) begin
                        ok     = 1'b1;
                        rd_val = MB_BUS_UV;
                    end
                end
            end else if (mb_dev0) begin
                unique case (cmd.func)
                    FN_SHUTDOWN: begin ok = 1'b1; want_shutdown = 1'b1; end
                    FN_REBOOT:   begin ok = 1'b1; want_reboot   = 1'b1; end
                    FN_VIDSEL,
                    FN_DVI:      ok = 1'b1;
                    default:     ok = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
    import cfg_cmd_pkg::*;
#(
    parameter int unsigned NUM_SENSORS = 4,
    parameter logic [NUM_SENSORS*32-1:0] SENSOR_UV =
        {32'd1_800_000, 32'd1_200_000, 32'd1_000_000, 32'd900_000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          shutdown_req,
    output logic          reboot_req
);
    logic [DW-1:0] data_q, ctrl_q;
    logic [1:0]    stat_q;
    logic          exec, launch;
    logic          t_ok, t_sd, t_rb;
    logic [DW-1:0] t_val;
    cmd_word_t     cmd;

    assign cmd    = cmd_word_t'(ctrl_q);
    assign launch = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[31];

    cfg_cmd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .exec   (exec)
    );

    cfg_cmd_target #(
        .NUM_SENSORS (NUM_SENSORS),
        .SENSOR_UV   (SENSOR_UV)
    ) u_target (
        .cmd           (cmd),
        .ok            (t_ok),
        .rd_val        (t_val),
        .want_shutdown (t_sd),
        .want_reboot   (t_rb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q       <= '0;
            ctrl_q       <= '0;
            stat_q       <= '0;
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
        end else if (exec) begin
            stat_q       <= {~t_ok, 1'b1};
            shutdown_req <= t_sd;
            reboot_req   <= t_rb;
            if (t_ok && !cmd.is_write) data_q <= t_val;
        end else begin
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
            if (bus_wr) begin
                unique case (bus_addr)
                    OFF_DATA: data_q <= bus_wdata;
                    OFF_CTRL: ctrl_q <= bus_wdata & CTRL_KEEP_MASK;
                    OFF_STAT: stat_q <= bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_DATA: bus_rdata = data_q;
            OFF_CTRL: bus_rdata = ctrl_q;
            OFF_STAT: bus_rdata = {30'd0, stat_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R3: every execution cycle ends with the done flag set
    a_r3_done_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> stat_q[0]);
    // R6: a refused command leaves the data register untouched
    a_r6_fault_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !t_ok) |=> $stable(data_q));
    // R7: request pulses last one cycle and never overlap
    a_r7_shutdown_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);
    a_r7_reboot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req);
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reboot_req));
    // R2: launch and spare bits never read back
    a_r2_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CTRL) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));
    // R9: status holds two bits only
    a_r9_stat_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_STAT) |-> (bus_rdata[31:2] == 30'd0));
endmodule

// File: tb/test_cfg_cmd_ctrl.sv
module test_cfg_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shutdown_req, reboot_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [7:0] A_DATA = 8'hA0, A_CTRL = 8'hA4, A_STAT = 8'hA8;
    localparam logic [31:0] GO = 32'h8000_0000, WR = 32'h4000_0000;
    logic [31:0] exp_uv [4] = '{32'd900_000, 32'd1_000_000, 32'd1_200_000, 32'd1_800_000};

    always #10 clk = ~clk;

    cfg_cmd_ctrl i_cfg_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shutdown_req(shutdown_req), .reboot_req(reboot_req)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(bit w, int sel, int fn, int site, int pos, int dev);
        return GO | (w ? WR : 32'd0) | (32'(sel) << 26) | (32'(fn) << 20)
             | (32'(site) << 16) | (32'(pos) << 12) | 32'(dev);
    endfunction

    // launch and wait for the commit edge; returns status
    task automatic run(logic [31:0] c, output logic [31:0] st);
        wr(A_CTRL, c);
        @(negedge clk);
        rd(A_STAT, st);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_DATA, v); chk("R1 data", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_STAT, v); chk("R1 stat", v, 0);
        chk("R1 pulses", {30'd0, shutdown_req, reboot_req}, 0);
        rd(8'h40, v); chk("R11 other offset", v, 0);
    endtask

    task automatic t_ctrl_store;
        logic [31:0] v;
        wr(A_CTRL, 32'h7FFF_FFFF);
        @(negedge clk);
        rd(A_CTRL, v); chk("R2 ctrl stored", v, 32'h7FF3_FFFF);
        rd(A_STAT, v); chk("R2 no launch", v, 0);
    endtask

    task automatic t_sensors;
        logic [31:0] v, st;
        for (int k = 0; k < 4; k++) begin
            run(mk(0, 0, 2, 1, 0, k), st);
            chk("R5 status", st, 1);
            rd(A_DATA, v); chk("R5 sensor value", v, exp_uv[k]);
        end
        run(mk(0, 0, 2, 1, 0, 4), st);
        chk("R6 out of range fault", st, 3);
        rd(A_DATA, v); chk("R6 data kept", v, exp_uv[3]);
    endtask

    task automatic t_mb_volt;
        logic [31:0] v, st;
        run(mk(0, 0, 2, 0, 0, 0), st);
        chk("R6 mb status", st, 1);
        rd(A_DATA, v); chk("R6 mb value", v, 32'd3_300_000);
        run(mk(0, 0, 2, 0, 0, 1), st); chk("R6 mb dev1 fault", st, 3);
        run(mk(0, 0, 5, 1, 0, 0), st); chk("R6 other fn fault", st, 3);
    endtask

    task automatic t_target;
        logic [31:0] st;
        run(mk(0, 1, 2, 1, 0, 0), st); chk("R4 ctl select", st, 3);
        run(mk(0, 0, 2, 1, 1, 0), st); chk("R4 position", st, 3);
        run(mk(0, 0, 2, 2, 0, 0), st); chk("R4 site 2", st, 3);
        run(mk(0, 0, 2, 1, 0, 0), st); chk("R4 valid", st, 1);
    endtask

    task automatic t_requests;
        logic [31:0] v, st;
        wr(A_DATA, 32'h55);
        wr(A_CTRL, mk(1, 0, 8, 0, 0, 0));
        chk("R7 no pulse yet", {31'd0, shutdown_req}, 0);
        @(negedge clk);
        chk("R7 shutdown high", {30'd0, shutdown_req, reboot_req}, 2);
        rd(A_STAT, st); chk("R7 shutdown status", st, 1);
        @(negedge clk);
        chk("R7 shutdown one cycle", {31'd0, shutdown_req}, 0);
        wr(A_CTRL, mk(1, 0, 9, 0, 0, 0));
        @(negedge clk);
        chk("R7 reboot high", {30'd0, shutdown_req, reboot_req}, 1);
        @(negedge clk);
        chk("R7 reboot one cycle", {31'd0, reboot_req}, 0);
        wr(A_CTRL, mk(1, 0, 8, 0, 0, 1));
        @(negedge clk);
        chk("R7 wrong dev no pulse", {30'd0, shutdown_req, reboot_req}, 0);
        rd(A_STAT, st); chk("R7 wrong dev fault", st, 3);
        rd(A_DATA, v); chk("R8 write keeps data", v, 32'h55);
    endtask

    task automatic t_nop_writes;
        logic [31:0] st;
        wr(A_CTRL, mk(1, 0, 7, 0, 0, 0));
        @(negedge clk);
        chk("R8 fn7 no pulse", {30'd0, shutdown_req, reboot_req}, 0);
        rd(A_STAT, st); chk("R8 fn7 ok", st, 1);
        run(mk(1, 0, 11, 0, 0, 0), st); chk("R8 fn11 ok", st, 1);
        run(mk(1, 0, 2, 0, 0, 0), st); chk("R8 fn2 write fault", st, 3);
    endtask

    task automatic t_status;
        logic [31:0] v;
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R9 low bits", v, 3);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R9 clear", v, 0);
    endtask

    task automatic t_timing;
        logic [31:0] v;
        wr(A_STAT, 0);
        wr(A_CTRL, mk(0, 0, 2, 0, 0, 0));
        rd(A_STAT, v); chk("R3 old status during exec", v, 0);
        @(negedge clk);
        rd(A_STAT, v); chk("R3 status after commit", v, 1);
    endtask

    task automatic t_exec_drop;
        logic [31:0] v;
        wr(A_DATA, 32'h1234);
        wr(A_CTRL, mk(0, 0, 2, 2, 0, 0));
        wr(A_DATA, 32'hDEAD);
        rd(A_DATA, v); chk("R10 data write dropped", v, 32'h1234);
        rd(A_STAT, v); chk("R10 status", v, 3);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_store();
        t_sensors();
        t_mb_volt();
        t_target();
        t_requests();
        t_nop_writes();
        t_status();
        t_timing();
        t_exec_drop();
        report();
    end
endmodule